// File: doc/BRIEF.md
# Packed-Decimal Digit Shifter

This unit moves the decimal digits of a signed packed-decimal number toward the high or low end by a signed count of whole digits. A move of one place toward the high end multiplies the value by ten. A move of one place toward the low end divides it by ten and drops the lowest digit, so the result is truncated. The sign nibble does not move. The sign class of the input (positive or negative) carries into the result. For positive results, a preference input selects which positive code is written.

Each accepted operand produces one registered result one clock later. The result comes with a set of condition flags: less than zero, zero, greater than zero, digits lost off the top, and malformed input. A datapath can take the result directly, and a branch unit can take the flags.

Top module: `pds_digit_shifter`

## Requirements
- R1: The data operand is 128 bits wide. Bits [3:0] hold the sign code. Digit k, for k = 1 to 31, sits in bits [4k+3:4k], and digit 1 is the least significant. Codes 0xB and 0xD mean negative. Codes 0xA, 0xC, 0xE and 0xF mean positive.
- R2: `shift_cnt` is read as an 8-bit two's-complement count n, covering -128 to +127.
- R3: When n is from 1 to 30, the magnitude moves n digits toward the high end (times 10^n). The low digit positions that are vacated read zero.
- R4: When n is from -1 to -30, the magnitude moves |n| digits toward the low end and the low digits are dropped (truncation). The vacated high positions read zero. When n is 0, the magnitude is returned unchanged.
- R5: When n >= 31 or n <= -31, the result magnitude is zero.
- R6: `flag_ovf` is 1 only when a move toward the high end discards at least one nonzero digit. It is never set for n <= 0.
- R7: A negative input yields sign code 0xD. A positive input yields 0xC when `pref_alt` is 0 and 0xF when `pref_alt` is 1. This applies even when the magnitude becomes zero.
- R8: For a valid input, exactly one of `flag_lt`, `flag_eq`, `flag_gt` is 1. `flag_eq` is 1 for a zero result magnitude. `flag_lt` is 1 for a negative nonzero result. `flag_gt` is 1 for a positive nonzero result.
- R9: The input is malformed when any digit nibble exceeds 9 or the sign code is below 0xA. A malformed input gives `flag_inv` = 1, `res` = 0, and the other four flags at 0.
- R10: The result, the flags and a one-cycle `out_valid` pulse appear at the first rising edge after `in_valid` is sampled high. While no operand is accepted, `res` and the flags hold their values.
- R11: Reset is synchronous and active low. It clears `out_valid`, `res` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept the operands on this edge |
| pref_alt | input | 1 | Positive code select: 0 gives 0xC, 1 gives 0xF |
| dec_opnd | input | 128 | Signed packed-decimal data operand |
| shift_cnt | input | 8 | Signed digit count taken from the second operand |
| out_valid | output | 1 | Result valid pulse |
| res | output | 128 | Shifted packed-decimal result |
| flag_lt | output | 1 | Result negative and nonzero |
| flag_eq | output | 1 | Result magnitude zero |
| flag_gt | output | 1 | Result positive and nonzero |
| flag_ovf | output | 1 | Nonzero digits lost on a high-end move |
| flag_inv | output | 1 | Malformed input operand |

## Verification
All results, and the flags and `out_valid` with them, are due at the first rising edge after the edge that samples `in_valid`. There is exactly one register between the operand ports and every output. The bench changes inputs on the falling edge, drops `in_valid` on the next falling edge, and reads the outputs there, half a period after the registering edge. One more falling edge later it checks that `out_valid` has returned low and that `res` still holds.

// File: rtl/pds_pkg.sv
// Package for the packed-decimal digit shifter.
// Holds the nibble width, the sign codes and a helper that classifies sign codes.
// Assumes: sign codes below 0xA are not legal signs.
package pds_pkg;
    localparam int NIB = 4;

    localparam logic [NIB-1:0] SGN_POS_STD = 4'hC;
    localparam logic [NIB-1:0] SGN_POS_ALT = 4'hF;
    localparam logic [NIB-1:0] SGN_NEG     = 4'hD;
    localparam logic [NIB-1:0] SGN_MIN_OK  = 4'hA;

    // Returns 1 for the two negative sign codes.
    function automatic logic sign_is_neg(input logic [NIB-1:0] code);
        return (code == 4'hB) || (code == 4'hD);
    endfunction
endpackage

// File: rtl/pds_validate.sv
// Operand checker: splits the sign nibble from the digit field and reports
// malformed input.
// Assumes: the sign nibble sits in the lowest nibble and digits follow above it.
module pds_validate
    import pds_pkg::*;
#(
    parameter int DIGITS = 31
) (
    input  logic [(DIGITS+1)*NIB-1:0] opnd,
    output logic [DIGITS*NIB-1:0]     mag,
    output logic                      neg,
    output logic                      bad
);
    logic [DIGITS-1:0] digit_bad;

    // One comparator per digit flags any nibble above 9.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign digit_bad[d] = (opnd[NIB*(d+1) +: NIB] > 4'd9);
    end

    // Split the fields and combine the fault terms.
    always_comb begin
        mag = opnd[(DIGITS+1)*NIB-1:NIB];
        neg = sign_is_neg(opnd[NIB-1:0]);
        bad = (|digit_bad) || (opnd[NIB-1:0] < SGN_MIN_OK);
    end
endmodule

// File: rtl/pds_shifter.sv
// Digit barrel shifter: moves the magnitude by a signed digit count in
// log2 stages and reports when nonzero digits are lost off the top.
// Assumes: CNT_W is wide enough to hold DIGITS, and DIGITS >= 2.
module pds_shifter
    import pds_pkg::*;
#(
    parameter int DIGITS = 31,
    parameter int CNT_W  = 8
) (
    input  logic [DIGITS*NIB-1:0] mag_in,
    input  logic [CNT_W-1:0]      cnt,
    output logic [DIGITS*NIB-1:0] mag_out,
    output logic                  ovf
);
    localparam int MW   = DIGITS * NIB;
    localparam int SH_W = $clog2(DIGITS);

    logic [CNT_W-1:0] cnt_abs;
    logic             go_left;
    logic             too_far;
    logic [SH_W-1:0]  amt;
    logic [MW-1:0]    lft [0:SH_W];
    logic [MW-1:0]    rgt [0:SH_W];
    logic [SH_W-1:0]  drop;

    // Decode direction, distance and the saturating case.
    always_comb begin
        cnt_abs = cnt[CNT_W-1] ? (~cnt + 1'b1) : cnt;
        go_left = !cnt[CNT_W-1] && (cnt != '0);
        too_far = (cnt_abs >= CNT_W'(DIGITS));
        amt     = cnt_abs[SH_W-1:0];
    end

    assign lft[0] = mag_in;
    assign rgt[0] = mag_in;

    // One stage per count bit, each moving by a power-of-two digit step.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        if (STEP >= DIGITS) begin : g_full
            assign lft[s+1] = amt[s] ? '0 : lft[s];
            assign rgt[s+1] = amt[s] ? '0 : rgt[s];
            assign drop[s]  = amt[s] & (|lft[s]);
        end else begin : g_part
            assign lft[s+1] = amt[s] ? (lft[s] << (NIB*STEP)) : lft[s];
            assign rgt[s+1] = amt[s] ? (rgt[s] >> (NIB*STEP)) : rgt[s];
            assign drop[s]  = amt[s] & (|lft[s][MW-1 -: NIB*STEP]);
        end
    end

    // Choose the chain that matches the direction, or clear the magnitude when saturating.
    always_comb begin
        if (too_far) begin
            mag_out = '0;
            ovf     = go_left && (|mag_in);
        end else if (go_left) begin
            mag_out = lft[SH_W];
            ovf     = |drop;
        end else begin
            mag_out = rgt[SH_W];
            ovf     = 1'b0;
        end
    end
endmodule

// File: rtl/pds_result.sv
// Result former: attaches the output sign code and derives the condition flags.
// Assumes: a malformed operand overrides every other outcome.
module pds_result
    import pds_pkg::*;
#(
    parameter int DIGITS = 31
) (
    input  logic [DIGITS*NIB-1:0]     mag,
    input  logic                      neg,
    input  logic                      bad,
    input  logic                      ovf_in,
    input  logic                      pref_alt,
    output logic [(DIGITS+1)*NIB-1:0] res,
    output logic [4:0]                flags
);
    logic             zero;
    logic [NIB-1:0]   sgn;

    // Pick the sign code and build the flag vector {lt,eq,gt,ovf,inv}.
    always_comb begin
        zero = (mag == '0);
        sgn  = neg ? SGN_NEG : (pref_alt ? SGN_POS_ALT : SGN_POS_STD);
        if (bad) begin
            res   = '0;
            flags = 5'b00001;
        end else begin
            res   = {mag, sgn};
            flags = {neg && !zero, zero, !neg && !zero, ovf_in, 1'b0};
        end
    end
endmodule

// File: rtl/pds_digit_shifter.sv
// Top of the packed-decimal digit shifter. Checks the operand, moves its
// digits by a signed count and registers the result and flags once.
// Assumes: shift_cnt is the count byte already taken from the second operand.
module pds_digit_shifter
    import pds_pkg::*;
#(
    parameter int DIGITS = 31,
    parameter int CNT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic                           pref_alt,
    input  logic [(DIGITS+1)*pds_pkg::NIB-1:0] dec_opnd,
    input  logic [CNT_W-1:0]               shift_cnt,
    output logic                           out_valid,
    output logic [(DIGITS+1)*pds_pkg::NIB-1:0] res,
    output logic                           flag_lt,
    output logic                           flag_eq,
    output logic                           flag_gt,
    output logic                           flag_ovf,
    output logic                           flag_inv
);
    localparam int MW = DIGITS * NIB;
    localparam int RW = (DIGITS + 1) * NIB;

    logic [MW-1:0] mag_raw;
    logic [MW-1:0] mag_sh;
    logic          is_neg;
    logic          is_bad;
    logic          sh_ovf;
    logic [RW-1:0] res_d;
    logic [4:0]    flags_d;

    pds_validate #(.DIGITS(DIGITS)) u_val (
        .opnd (dec_opnd),
        .mag  (mag_raw),
        .neg  (is_neg),
        .bad  (is_bad)
    );

    pds_shifter #(.DIGITS(DIGITS), .CNT_W(CNT_W)) u_sh (
        .mag_in  (mag_raw),
        .cnt     (shift_cnt),
        .mag_out (mag_sh),
        .ovf     (sh_ovf)
    );

    pds_result #(.DIGITS(DIGITS)) u_res (
        .mag      (mag_sh),
        .neg      (is_neg),
        .bad      (is_bad),
        .ovf_in   (sh_ovf),
        .pref_alt (pref_alt),
        .res      (res_d),
        .flags    (flags_d)
    );

    // Output register: loads on an accepted operand and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res       <= '0;
            {flag_lt, flag_eq, flag_gt, flag_ovf, flag_inv} <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res <= res_d;
                {flag_lt, flag_eq, flag_gt, flag_ovf, flag_inv} <= flags_d;
            end
        end
    end

    // R10: the valid pulse trails the accepted operand by one edge
    a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R10: with no operand accepted, the result holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res));

    // R6: a count toward the low end never reports lost digits
    a_r6_no_ovf_right: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_cnt[CNT_W-1]) |=> !flag_ovf);

    // R8: a valid result raises exactly one comparison flag
    a_r8_one_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flag_inv) |-> ($countones({flag_lt, flag_eq, flag_gt}) == 1));

    // R9: a malformed operand zeroes the result and the other flags
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv |-> (!flag_lt && !flag_eq && !flag_gt && !flag_ovf && res == '0));

    // R7: a valid result always carries one of the three output sign codes
    a_r7_sign_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flag_inv) |->
        (res[NIB-1:0] == SGN_NEG || res[NIB-1:0] == SGN_POS_STD || res[NIB-1:0] == SGN_POS_ALT));

    // R11: reset clears the valid pulse and the result
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && res == '0 && !flag_inv));
endmodule

// File: tb/tb_pds_digit_shifter.sv
`timescale 1ns/1ps
module tb_pds_digit_shifter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         pref_alt = 1'b0;
    logic [127:0] dec_opnd = '0;
    logic [7:0]   shift_cnt = '0;
    logic         out_valid;
    logic [127:0] res;
    logic         flag_lt, flag_eq, flag_gt, flag_ovf, flag_inv;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pds_digit_shifter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pref_alt(pref_alt),
        .dec_opnd(dec_opnd), .shift_cnt(shift_cnt), .out_valid(out_valid),
        .res(res), .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt),
        .flag_ovf(flag_ovf), .flag_inv(flag_inv)
    );

    // Vector table: {magnitude[63:0], count[7:0], sign code[3:0], pref_alt}
    localparam int NV = 10;
    localparam logic [76:0] VEC [0:NV-1] = '{
        {64'd1020304,      8'h01, 4'hC, 1'b0},
        {64'd1020304,      8'hFF, 4'hC, 1'b0},
        {64'd1234567,      8'h00, 4'hC, 1'b1},
        {64'd98765,        8'h05, 4'hD, 1'b0},
        {64'd987654321,    8'hFB, 4'hB, 1'b0},
        {64'd55,           8'h1F, 4'hC, 1'b0},
        {64'd123456789,    8'hE1, 4'hA, 1'b1},
        {64'd42,           8'hFB, 4'hC, 1'b0},
        {64'd0,            8'h01, 4'hD, 1'b0},
        {64'd999999999999, 8'h05, 4'hF, 1'b1}
    };

    function automatic logic [127:0] p10(input int n);
        logic [127:0] r = 128'd1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [127:0] to_pd(input logic [127:0] v, input logic [3:0] sg);
        logic [127:0] r = '0;
        logic [127:0] t = v;
        r[3:0] = sg;
        for (int i = 1; i <= 31; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Integer model of the requirements: expected result and {lt,eq,gt,ovf,inv}.
    task automatic model(input logic [127:0] m, input logic [3:0] sg, input logic [7:0] c,
                         input logic pf, output logic [127:0] er, output logic [4:0] ef);
        int ci = int'($signed(c));
        logic [127:0] rm;
        logic ov = 1'b0;
        logic ng = (sg == 4'hB) || (sg == 4'hD);
        if (ci >= 31) begin rm = '0; ov = (m != 0); end
        else if (ci > 0) begin ov = (m >= p10(31 - ci)); rm = (m % p10(31 - ci)) * p10(ci); end
        else if (ci <= -31) rm = '0;
        else rm = m / p10(-ci);
        er = to_pd(rm, ng ? 4'hD : (pf ? 4'hF : 4'hC));
        ef = {ng && rm != 0, rm == 0, !ng && rm != 0, ov, 1'b0};
    endtask

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operand on a falling edge; return one edge after it was registered.
    task automatic apply(input logic [127:0] op, input logic [7:0] c, input logic pf);
        @(negedge clk);
        dec_opnd = op; shift_cnt = c; pref_alt = pf; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [4:0] flags();
        return {flag_lt, flag_eq, flag_gt, flag_ovf, flag_inv};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] er;
        logic [4:0]   ef;
        logic [127:0] max9;
        logic [127:0] op;
        // R11: reset state
        dec_opnd = to_pd(128'd7, 4'hC); in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 out_valid in reset", {127'd0, out_valid}, 128'd0);
        check("R11 res in reset", res, 128'd0);
        check("R11 flags in reset", {123'd0, flags()}, 128'd0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R1/R3/R4/R5/R7/R8: table walk against the integer model
        for (int v = 0; v < NV; v++) begin
            logic [63:0] m = VEC[v][76:13];
            logic [7:0]  c = VEC[v][12:5];
            logic [3:0]  s = VEC[v][4:1];
            logic        p = VEC[v][0];
            model({64'd0, m}, s, c, p, er, ef);
            apply(to_pd({64'd0, m}, s), c, p);
            check($sformatf("R10 out_valid vec%0d", v), {127'd0, out_valid}, 128'd1);
            check($sformatf("R1/R3/R4/R5/R7 res vec%0d", v), res, er);
            check($sformatf("R8 flags vec%0d", v), {123'd0, flags()}, {123'd0, ef});
        end

        // R10: one-cycle pulse, result held while idle
        op = res;
        @(negedge clk);
        check("R10 pulse ends", {127'd0, out_valid}, 128'd0);
        check("R10 result held", res, op);

        // R6: all nines moved up one digit loses the top nine
        max9 = p10(31) - 1;
        model(max9, 4'hC, 8'h01, 1'b0, er, ef);
        apply(to_pd(max9, 4'hC), 8'h01, 1'b0);
        check("R6 ovf result", res, er);
        check("R6 ovf flag", {127'd0, flag_ovf}, 128'd1);

        // R6: all nines with count 0 keeps every digit, no overflow
        apply(to_pd(max9, 4'hD), 8'h00, 1'b0);
        check("R6 no ovf at zero count", {127'd0, flag_ovf}, 128'd0);
        check("R4 identity", res, to_pd(max9, 4'hD));

        // R6: all nines moved down never overflows
        model(max9, 4'hC, 8'hFF, 1'b0, er, ef);
        apply(to_pd(max9, 4'hC), 8'hFF, 1'b0);
        check("R6 right no ovf", {123'd0, flags()}, {123'd0, ef});

        // R2/R5: most negative count gives zero magnitude
        apply(to_pd(128'd31415, 4'hC), 8'h80, 1'b1);
        check("R2/R5 count -128 res", res, to_pd(128'd0, 4'hF));
        check("R2 count -128 flags", {123'd0, flags()}, 128'b01000);

        // R5/R6: count 127 on nonzero clears magnitude and overflows
        apply(to_pd(128'd1, 4'hD), 8'h7F, 1'b0);
        check("R5 count 127 res", res, to_pd(128'd0, 4'hD));
        check("R6 count 127 flags", {123'd0, flags()}, 128'b01010);

        // R9: a digit nibble of 0xB
        op = to_pd(128'd12345, 4'hC); op[15:12] = 4'hB;
        apply(op, 8'h01, 1'b0);
        check("R9 bad digit res", res, 128'd0);
        check("R9 bad digit flags", {123'd0, flags()}, 128'b00001);

        // R9: sign code 0x3 is malformed
        apply(to_pd(128'd12345, 4'h3), 8'hFF, 1'b0);
        check("R9 bad sign flags", {123'd0, flags()}, 128'b00001);

        // R7: alternate positive code 0xE maps to 0xC with pref_alt low
        apply(to_pd(128'd8, 4'hE), 8'h02, 1'b0);
        check("R7 positive code", res, to_pd(128'd800, 4'hC));

        // R11: reset mid-run clears outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 re-reset res", res, 128'd0);
        check("R11 re-reset flags", {122'd0, out_valid, flags()}, 128'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule